// File: doc/BRIEF.md
# DMA Channel Control Registers and Interrupt Logic

This block is the software-facing side of a peripheral DMA channel. It holds a control/status word, a 32-bit memory address and a 32-bit byte count behind a simple register port, and hands the resulting settings to a separate data-movement engine. The engine reports back through pulse inputs: terminal count reached, error seen and a new byte-packing count.

The block merges three interrupt sources (terminal count not yet acknowledged, the peripheral's own interrupt line, and error status) into one interrupt output, gated by an enable bit. Software acknowledges terminal count by reading the control word, not by writing it. A flush of the channel status is requested by toggling a control bit, so any write whose flush bit differs from the stored one counts as a flush. A transfer start pulse is sent to the engine when the peripheral raises its request while the channel is enabled, or when software turns the enable bit on while a request is already pending.

Top module: `dmac_csr_top`

## Requirements
- R1: Interrupt pending (control bit 0) equals (terminal count AND NOT acknowledged) OR the peripheral interrupt input, and is updated at the same clock edge as any of its inputs.
- R2: `irq_out` is high exactly when (interrupt pending OR error pending) AND interrupt enable (control bit 4) are all in effect after the same edge; error pending is control bit 1.
- R3: Reading offset 0 while terminal count (control bit 10) is set marks it acknowledged; after that edge interrupt pending falls unless the peripheral interrupt is high. The read data still shows the pre-read value.
- R4: A write to offset 0 replaces only the enable (bit 4), flush (bit 5), direction (bit 6), channel enable (bit 7) and count enable (bit 8) bits; pending, error, pack count (bits 3:2), request (bit 9) and terminal count are unchanged. Flush is write-only and reads as 0.
- R5: A control write whose bit 5 differs from the stored flush bit clears pack count, error pending and terminal count at that edge; interrupts are re-evaluated.
- R6: A control write that turns bit 7 from 0 to 1 while request pending is already set produces a one-cycle `xfer_start` pulse; a write that leaves bit 7 at 1 produces none.
- R7: Request pending (bit 9) follows `periph_req_in` one edge later; a rising request with channel enable in effect produces a one-cycle `xfer_start` pulse, and none when enable is 0.
- R8: The peripheral interrupt input is captured at each edge, so a change reaches `irq_out` after one edge when enabled.
- R9: Writes to offset 1 (address) and offset 2 (byte count) store all 32 bits, readable back and driven on `dma_addr` and `dma_count`.
- R10: After reset all three registers read 0, `irq_out` and `xfer_start` are 0, and offset 3 reads 0.
- R11: `eng_tc_set` sets terminal count and clears the acknowledgement, `eng_err_set` sets error pending, and `eng_pack_ld` loads the pack count from `eng_pack_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| periph_req_in | input | 1 | Peripheral data request level |
| periph_irq_in | input | 1 | Peripheral interrupt level |
| eng_tc_set | input | 1 | Engine pulse: terminal count reached |
| eng_err_set | input | 1 | Engine pulse: error seen |
| eng_pack_ld | input | 1 | Engine pulse: load pack count |
| eng_pack_val | input | 2 | New pack count |
| xfer_start | output | 1 | One-cycle transfer start pulse to engine |
| xfer_dir | output | 1 | Direction bit (1 = peripheral to memory) |
| cnt_en | output | 1 | Byte-count enable bit |
| dma_addr | output | DW | Current address register |
| dma_count | output | DW | Current byte-count register |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Every result of this block is due at the first rising edge after its stimulus: read data, status bits, `irq_out` and the `xfer_start` pulse are all registered from next-state values, so there is no extra cycle of lag between a peripheral interrupt change and the output. The bench drives all inputs at the falling edge and compares outputs at the following falling edge, one edge later; read results go into a queue and a monitor pops one per completed read. The single-cycle start pulse is checked at that falling edge and again one cycle later to confirm it has ended.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;
  // control word bit positions
  localparam int B_PEND    = 0;
  localparam int B_ERR     = 1;
  localparam int B_PACK_LO = 2;
  localparam int PACK_W    = 2;
  localparam int B_IEN     = 4;
  localparam int B_FLUSH   = 5;
  localparam int B_DIR     = 6;
  localparam int B_EN      = 7;
  localparam int B_CNT     = 8;
  localparam int B_REQ     = 9;
  localparam int B_TC      = 10;
  // writable field span
  localparam int WF_LO     = B_IEN;
  localparam int WF_HI     = B_CNT;
  localparam int WF_W      = WF_HI - WF_LO + 1;
  // register offsets
  localparam int OFF_CTRL  = 0;
  localparam int OFF_ADDR  = 1;
  localparam int OFF_COUNT = 2;
  localparam int NUM_WORDS = 2;
endpackage

// File: rtl/dmac_word_reg.sv
module dmac_word_reg #(
  parameter int DW     = 32,
  parameter int AW     = 2,
  parameter int OFFSET = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam logic [AW-1:0] MY_OFF = AW'(OFFSET);

  always_ff @(posedge clk) begin
    if (rst)                      q <= '0;
    else if (wr && addr == MY_OFF) q <= wdata;
  end
endmodule

// File: rtl/dmac_ctl_bits.sv
module dmac_ctl_bits
  import dmac_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [WF_W-1:0]   wfield,
  input  logic              periph_req_in,
  input  logic              eng_err_set,
  input  logic              eng_pack_ld,
  input  logic [PACK_W-1:0] eng_pack_val,
  output logic              flush_evt,
  output logic              ien_n,
  output logic              err_n,
  output logic              ien_q,
  output logic              dir_q,
  output logic              en_q,
  output logic              cnt_q,
  output logic              req_q,
  output logic              err_q,
  output logic [PACK_W-1:0] pack_q,
  output logic              start_q
);
  localparam int I_IEN   = B_IEN   - WF_LO;
  localparam int I_FLUSH = B_FLUSH - WF_LO;
  localparam int I_DIR   = B_DIR   - WF_LO;
  localparam int I_EN    = B_EN    - WF_LO;
  localparam int I_CNT   = B_CNT   - WF_LO;

  logic              flush_q, flush_n, dir_n, en_n, cnt_n, start_n;
  logic [PACK_W-1:0] pack_n;
  logic              req_rise, en_turn_on;

  assign flush_evt = ctrl_wr && (wfield[I_FLUSH] != flush_q);

  always_comb begin
    ien_n   = ien_q;
    flush_n = flush_q;
    dir_n   = dir_q;
    en_n    = en_q;
    cnt_n   = cnt_q;
    if (ctrl_wr) begin
      ien_n   = wfield[I_IEN];
      flush_n = wfield[I_FLUSH];
      dir_n   = wfield[I_DIR];
      en_n    = wfield[I_EN];
      cnt_n   = wfield[I_CNT];
    end
    err_n  = err_q;
    pack_n = pack_q;
    if (flush_evt) begin
      err_n  = 1'b0;
      pack_n = '0;
    end
    if (eng_err_set) err_n  = 1'b1;
    if (eng_pack_ld) pack_n = eng_pack_val;
  end

  assign req_rise   = periph_req_in && !req_q;
  assign en_turn_on = ctrl_wr && wfield[I_EN] && !en_q;
  assign start_n    = (req_rise && en_n) || (en_turn_on && req_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= 1'b0;
      flush_q <= 1'b0;
      dir_q   <= 1'b0;
      en_q    <= 1'b0;
      cnt_q   <= 1'b0;
      req_q   <= 1'b0;
      err_q   <= 1'b0;
      pack_q  <= '0;
      start_q <= 1'b0;
    end else begin
      ien_q   <= ien_n;
      flush_q <= flush_n;
      dir_q   <= dir_n;
      en_q    <= en_n;
      cnt_q   <= cnt_n;
      req_q   <= periph_req_in;
      err_q   <= err_n;
      pack_q  <= pack_n;
      start_q <= start_n;
    end
  end
endmodule

// File: rtl/dmac_irq_unit.sv
module dmac_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic eng_tc_set,
  input  logic flush_evt,
  input  logic ctrl_rd,
  input  logic periph_irq_in,
  input  logic ien_n,
  input  logic err_n,
  output logic tc_q,
  output logic pend_q,
  output logic irq_q
);
  logic tc_n, ack_q, ack_n, pend_n, irq_n;

  always_comb begin
    tc_n  = tc_q;
    ack_n = ack_q;
    if (ctrl_rd && tc_q) ack_n = 1'b1;
    if (flush_evt)       tc_n  = 1'b0;
    if (eng_tc_set) begin
      tc_n  = 1'b1;
      ack_n = 1'b0;
    end
    pend_n = (tc_n && !ack_n) || periph_irq_in;
    irq_n  = (pend_n || err_n) && ien_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= 1'b0;
      ack_q  <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tc_q   <= tc_n;
      ack_q  <= ack_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
    end
  end
endmodule

// File: rtl/dmac_csr_top.sv
module dmac_csr_top
  import dmac_csr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              periph_req_in,
  input  logic              periph_irq_in,
  input  logic              eng_tc_set,
  input  logic              eng_err_set,
  input  logic              eng_pack_ld,
  input  logic [PACK_W-1:0] eng_pack_val,
  output logic              xfer_start,
  output logic              xfer_dir,
  output logic              cnt_en,
  output logic [DW-1:0]     dma_addr,
  output logic [DW-1:0]     dma_count,
  output logic              irq_out
);
  localparam logic [AW-1:0] A_CTRL  = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_ADDR  = AW'(OFF_ADDR);
  localparam logic [AW-1:0] A_COUNT = AW'(OFF_COUNT);

  logic              ctrl_wr, ctrl_rd, flush_evt, ien_n, err_n;
  logic              ien_q, en_q, req_q, err_q, tc_q, pend_q;
  logic [PACK_W-1:0] pack_q;
  logic [DW-1:0]     word_q [NUM_WORDS];
  logic [DW-1:0]     ctrl_view;

  assign ctrl_wr = reg_wr && reg_addr == A_CTRL;
  assign ctrl_rd = reg_rd && reg_addr == A_CTRL;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    dmac_word_reg #(.DW(DW), .AW(AW), .OFFSET(OFF_ADDR + g)) u_word (
      .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .q(word_q[g])
    );
  end

  dmac_ctl_bits u_ctl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr),
    .wfield(reg_wdata[WF_HI:WF_LO]),
    .periph_req_in(periph_req_in), .eng_err_set(eng_err_set),
    .eng_pack_ld(eng_pack_ld), .eng_pack_val(eng_pack_val),
    .flush_evt(flush_evt), .ien_n(ien_n), .err_n(err_n),
    .ien_q(ien_q), .dir_q(xfer_dir), .en_q(en_q), .cnt_q(cnt_en),
    .req_q(req_q), .err_q(err_q), .pack_q(pack_q), .start_q(xfer_start)
  );

  dmac_irq_unit u_irq (
    .clk(clk), .rst(rst), .eng_tc_set(eng_tc_set), .flush_evt(flush_evt),
    .ctrl_rd(ctrl_rd), .periph_irq_in(periph_irq_in),
    .ien_n(ien_n), .err_n(err_n),
    .tc_q(tc_q), .pend_q(pend_q), .irq_q(irq_out)
  );

  always_comb begin
    ctrl_view                       = '0;
    ctrl_view[B_PEND]               = pend_q;
    ctrl_view[B_ERR]                = err_q;
    ctrl_view[B_PACK_LO +: PACK_W]  = pack_q;
    ctrl_view[B_IEN]                = ien_q;
    ctrl_view[B_DIR]                = xfer_dir;
    ctrl_view[B_EN]                 = en_q;
    ctrl_view[B_CNT]                = cnt_en;
    ctrl_view[B_REQ]                = req_q;
    ctrl_view[B_TC]                 = tc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_view;
        A_ADDR:  reg_rdata <= word_q[0];
        A_COUNT: reg_rdata <= word_q[1];
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign dma_addr  = word_q[0];
  assign dma_count = word_q[1];
endmodule

// File: rtl/dmac_csr_chk.sv
module dmac_csr_chk #(
  parameter int PACK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_wr,
  input logic              ctrl_rd,
  input logic              flush_evt,
  input logic              periph_irq_in,
  input logic              eng_tc_set,
  input logic              eng_err_set,
  input logic              eng_pack_ld,
  input logic              ien_q,
  input logic              en_q,
  input logic              tc_q,
  input logic              err_q,
  input logic              pend_q,
  input logic [PACK_W-1:0] pack_q,
  input logic              xfer_start,
  input logic              irq_out
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  // R2: no interrupt without the enable bit
  p_irq_gate_r2: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ien_q);

  // R3: a control read acknowledges terminal count
  p_ack_read_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(ctrl_rd && tc_q && !eng_tc_set)) |-> pend_q == $past(periph_irq_in));

  // R4: status bits survive a plain control write
  p_ro_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(ctrl_wr && !flush_evt && !eng_tc_set && !eng_err_set && !eng_pack_ld))
    |-> (tc_q == $past(tc_q) && err_q == $past(err_q) && pack_q == $past(pack_q)));

  // R5: flush change clears status
  p_flush_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(flush_evt && !eng_tc_set && !eng_err_set && !eng_pack_ld))
    |-> (!tc_q && !err_q && pack_q == '0));

  // R6: a start always comes with the channel enabled
  p_start_en_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> en_q);

  // R7: the start is a single-cycle pulse
  p_start_once_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);
endmodule

bind dmac_csr_top dmac_csr_chk #(.PACK_W(dmac_csr_pkg::PACK_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
  .flush_evt(flush_evt), .periph_irq_in(periph_irq_in),
  .eng_tc_set(eng_tc_set), .eng_err_set(eng_err_set), .eng_pack_ld(eng_pack_ld),
  .ien_q(ien_q), .en_q(en_q), .tc_q(tc_q), .err_q(err_q), .pend_q(pend_q),
  .pack_q(pack_q), .xfer_start(xfer_start), .irq_out(irq_out)
);

// File: tb/test_dmac_csr_top.sv
module test_dmac_csr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req_in = 1'b0, periph_irq_in = 1'b0;
  logic        eng_tc_set = 1'b0, eng_err_set = 1'b0, eng_pack_ld = 1'b0;
  logic [1:0]  eng_pack_val = '0;
  logic        xfer_start, xfer_dir, cnt_en, irq_out;
  logic [31:0] dma_addr, dma_count;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_q = 1'b0;

  always #4 clk = ~clk;

  dmac_csr_top i_dmac_csr_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req_in(periph_req_in),
    .periph_irq_in(periph_irq_in), .eng_tc_set(eng_tc_set), .eng_err_set(eng_err_set),
    .eng_pack_ld(eng_pack_ld), .eng_pack_val(eng_pack_val), .xfer_start(xfer_start),
    .xfer_dir(xfer_dir), .cnt_en(cnt_en), .dma_addr(dma_addr), .dma_count(dma_count),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one comparison per completed read
  always @(posedge clk) rd_q <= reg_rd;
  always @(negedge clk) begin
    if (rd_q && !rst) begin
      rd_item_t it;
      if (sb_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else begin
        it = sb_q.pop_front();
        chk(it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    it.exp = exp; it.tag = tag; sb_q.push_back(it);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq_out", {31'd0, irq_out}, 32'd0);
    chk("R10 xfer_start", {31'd0, xfer_start}, 32'd0);
    rd(2'd0, 32'h0, "R10 ctrl");
    rd(2'd1, 32'h0, "R10 addr");
    rd(2'd2, 32'h0, "R10 count");
    rd(2'd3, 32'h0, "R10 unused offset");
    // R9 full-width address and count
    wr(2'd1, 32'hDEADBEEF);
    wr(2'd2, 32'h0001_2345);
    rd(2'd1, 32'hDEADBEEF, "R9 addr");
    rd(2'd2, 32'h0001_2345, "R9 count");
    chk("R9 dma_addr", dma_addr, 32'hDEADBEEF);
    chk("R9 dma_count", dma_count, 32'h0001_2345);
    // R4 masking: all ones sets only writable bits, flush reads 0
    wr(2'd0, 32'hFFFF_FFFF);              // flush stored 1
    chk("R6 no request no start", {31'd0, xfer_start}, 32'd0);
    rd(2'd0, 32'h1D0, "R4 ctrl after all-ones write");
    chk("R4 xfer_dir", {31'd0, xfer_dir}, 32'd1);
    chk("R4 cnt_en", {31'd0, cnt_en}, 32'd1);
    // R1/R2 terminal count interrupt
    @(negedge clk); eng_tc_set = 1'b1;
    @(negedge clk); eng_tc_set = 1'b0;
    chk("R2 irq on tc", {31'd0, irq_out}, 32'd1);
    rd(2'd0, 32'h5D1, "R1 pending with tc");
    chk("R3 irq after ack read", {31'd0, irq_out}, 32'd0);
    rd(2'd0, 32'h5D0, "R3 pending cleared by read");
    // R8 peripheral interrupt
    @(negedge clk); periph_irq_in = 1'b1;
    @(negedge clk);
    chk("R8 irq follows input", {31'd0, irq_out}, 32'd1);
    rd(2'd0, 32'h5D1, "R1 pending from peripheral");
    periph_irq_in = 1'b0;
    @(negedge clk);
    chk("R8 irq drops with input", {31'd0, irq_out}, 32'd0);
    // R11 error and pack load, R2 error path
    @(negedge clk); eng_err_set = 1'b1;
    @(negedge clk); eng_err_set = 1'b0;
    chk("R2 irq on error", {31'd0, irq_out}, 32'd1);
    @(negedge clk); eng_pack_ld = 1'b1; eng_pack_val = 2'd3;
    @(negedge clk); eng_pack_ld = 1'b0;
    rd(2'd0, 32'h5D2 | 32'hC, "R11 error and pack");
    // R2 gate: clear enable, flush unchanged (bit5 kept 1)
    wr(2'd0, 32'h1E0);
    chk("R2 irq gated off", {31'd0, irq_out}, 32'd0);
    rd(2'd0, 32'h5CE, "R4 status kept on write");
    // R5 flush by toggle 1->0
    wr(2'd0, 32'h1D0);
    rd(2'd0, 32'h1D0, "R5 flush clears tc err pack");
    chk("R5 irq after flush", {31'd0, irq_out}, 32'd0);
    // R11 new tc clears acknowledgement
    @(negedge clk); eng_tc_set = 1'b1;
    @(negedge clk); eng_tc_set = 1'b0;
    chk("R11 tc re-raises irq", {31'd0, irq_out}, 32'd1);
    wr(2'd0, 32'h1F0);                    // flush 0->1
    chk("R5 irq after second flush", {31'd0, irq_out}, 32'd0);
    rd(2'd0, 32'h1D0, "R5 second flush");
    // R7 request rising with enable
    @(negedge clk); periph_req_in = 1'b1;
    @(negedge clk);
    chk("R7 start on request", {31'd0, xfer_start}, 32'd1);
    @(negedge clk);
    chk("R7 start one cycle", {31'd0, xfer_start}, 32'd0);
    rd(2'd0, 32'h3D0, "R7 request pending bit");
    periph_req_in = 1'b0;
    @(negedge clk);
    rd(2'd0, 32'h1D0, "R7 request cleared");
    // R7 no start when disabled; R6 start on enable turn-on
    wr(2'd0, 32'h170);
    chk("R6 disable no start", {31'd0, xfer_start}, 32'd0);
    @(negedge clk); periph_req_in = 1'b1;
    @(negedge clk);
    chk("R7 no start while disabled", {31'd0, xfer_start}, 32'd0);
    wr(2'd0, 32'h1F0);
    chk("R6 start on enable", {31'd0, xfer_start}, 32'd1);
    wr(2'd0, 32'h1F0);
    chk("R6 no start without change", {31'd0, xfer_start}, 32'd0);
    periph_req_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("scoreboard drained", sb_q.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule